// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Generator

This block drives the four switches of a full-bridge converter at a fixed carrier period. The period is set as a count of clock cycles. A reference counter runs from zero to the period minus one and is pulled back to zero by an external synchronisation pulse. That pulse is normally taken from a loop that tracks the primary-side voltage. Each of the two legs makes a square wave with a 50% duty. Each leg drives a high-side and a low-side switch that are never on together.

Two signed commands, both given in clock counts, place the legs in time. The bridge offset places leg A relative to the reference counter. A quarter of the period corresponds to 90° and a third of the period to 120°. The leg shift places leg B relative to leg A. Half the period is 180°. A positive shift makes leg B lag leg A, which means power flows forward. A negative shift makes leg B lead leg A, which means power flows in reverse. The commands and the period are sampled only when a carrier period starts, so a change made mid-period cannot cut a pulse short.

Top module: `hbridge_phase_gen`

## Requirements
- R1: While rst_n is low, all four gate outputs are low at every clock edge.
- R2: After reset, the two outputs of each leg are complementary: exactly one of leg_a_hi/leg_a_lo is high, and the same holds for leg B.
- R3: The reference counter counts 0 up to P-1 and then wraps to 0, where P is the latched period. The gate outputs are registered, so the outputs after an edge reflect the counter value held before that edge.
- R4: A high sync_i at a clock edge restarts the reference counter at 0 at that edge. This also holds mid-period.
- R5: Leg A's high-side output is high when (counter - offset) mod P < floor(P/2), and low otherwise. Its rising edge therefore sits at counter value offset mod P.
- R6: Leg B's high-side output follows the rule of R5 with phase offset + shift. A positive shift delays leg B after leg A by that many counts. A negative shift advances leg B ahead of leg A.
- R7: The latched shift is clamped to the range ±floor(P/2), and the latched offset is clamped to the range ±P.
- R8: period_i, shift_i and offset_i are sampled only at a period start, which is a counter wrap or a sync pulse. A change between starts has no effect until the next start.
- R9: A period request below 2 is latched as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_i | input | 1 | Reference restart pulse |
| period_i | input | CNT_W | Carrier period in clock counts |
| shift_i | input | CNT_W | Signed leg B shift relative to leg A, in counts |
| offset_i | input | CNT_W | Signed leg A offset relative to the reference, in counts |
| leg_a_hi | output | 1 | Leg A high-side gate |
| leg_a_lo | output | 1 | Leg A low-side gate |
| leg_b_hi | output | 1 | Leg B high-side gate |
| leg_b_lo | output | 1 | Leg B low-side gate |

## Verification
A wrong reference counter or a wrong latched command shows up at the gate pins within one carrier period. One or both legs then rise at the wrong count, or hold high for the wrong number of cycles. A command latched at the wrong moment shows up as a change in the middle of the period, rather than at the first full period after the change. The bench compares every output on every cycle of two or more periods against a modular-arithmetic reference. Any error is therefore seen no later than the first edge that it displaces.

// File: rtl/hbridge_phase_gen.sv
module hbridge_phase_gen #(
  parameter int CNT_W      = 12,
  parameter int DEF_PERIOD = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_i,
  input  logic [CNT_W-1:0]        period_i,
  input  logic signed [CNT_W-1:0] shift_i,
  input  logic signed [CNT_W-1:0] offset_i,
  output logic                    leg_a_hi,
  output logic                    leg_a_lo,
  output logic                    leg_b_hi,
  output logic                    leg_b_lo
);
  localparam int W = CNT_W + 3;
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(2);
  localparam logic [CNT_W-1:0] RST_P = CNT_W'(DEF_PERIOD);

  logic [CNT_W-1:0]    rc, per_q, per_n, half_q;
  logic signed [W-1:0] sh_q, off_q, sh_n, off_n, full_n, half_n, full_q, rc_s;
  logic [CNT_W-1:0]    ph_a, ph_b;
  logic                start;

  function automatic logic [CNT_W-1:0] wrap(input logic signed [W-1:0] d,
                                            input logic signed [W-1:0] p);
    logic signed [W-1:0] v;
    v = d;
    if (v < 0)  v = v + p;
    if (v < 0)  v = v + p;
    if (v < 0)  v = v + p;
    if (v >= p) v = v - p;
    if (v >= p) v = v - p;
    return v[CNT_W-1:0];
  endfunction

  assign start  = sync_i || (rc >= per_q - 1'b1);
  assign per_n  = (period_i < MIN_P) ? MIN_P : period_i;
  assign full_n = $signed({3'b000, per_n});
  assign half_n = full_n >>> 1;
  assign full_q = $signed({3'b000, per_q});
  assign half_q = per_q >> 1;
  assign rc_s   = $signed({3'b000, rc});

  always_comb begin
    sh_n = W'(shift_i);
    if (sh_n > half_n)  sh_n = half_n;
    if (sh_n < -half_n) sh_n = -half_n;
    off_n = W'(offset_i);
    if (off_n > full_n)  off_n = full_n;
    if (off_n < -full_n) off_n = -full_n;
  end

  assign ph_a = wrap(rc_s - off_q, full_q);
  assign ph_b = wrap(rc_s - off_q - sh_q, full_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rc       <= '0;
      per_q    <= RST_P;
      sh_q     <= '0;
      off_q    <= '0;
      leg_a_hi <= 1'b0;
      leg_a_lo <= 1'b0;
      leg_b_hi <= 1'b0;
      leg_b_lo <= 1'b0;
    end else begin
      rc       <= start ? '0 : rc + 1'b1;
      if (start) begin
        per_q <= per_n;
        sh_q  <= sh_n;
        off_q <= off_n;
      end
      leg_a_hi <= (ph_a < half_q);
      leg_a_lo <= !(ph_a < half_q);
      leg_b_hi <= (ph_b < half_q);
      leg_b_lo <= !(ph_b < half_q);
    end
  end
endmodule

module hbridge_phase_gen_chk #(
  parameter int CNT_W = 12,
  parameter int W     = CNT_W + 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sync_i,
  input logic                start,
  input logic [CNT_W-1:0]    rc,
  input logic [CNT_W-1:0]    per_q,
  input logic signed [W-1:0] sh_q,
  input logic signed [W-1:0] off_q,
  input logic                leg_a_hi,
  input logic                leg_a_lo,
  input logic                leg_b_hi,
  input logic                leg_b_lo
);
  logic signed [W-1:0] p_s;
  assign p_s = $signed({3'b000, per_q});

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> (!leg_a_hi && !leg_a_lo && !leg_b_hi && !leg_b_lo));
  // R2
  leg_a_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(leg_a_hi && leg_a_lo));
  // R2
  leg_b_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(leg_b_hi && leg_b_lo));
  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rc < per_q);
  // R4
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (rc == '0));
  // R7
  shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (2 * sh_q <= p_s) && (2 * sh_q >= -p_s) && (off_q <= p_s) && (off_q >= -p_s));
  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(sh_q) && $stable(off_q) && $stable(per_q)));
  // R9
  per_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_q >= CNT_W'(2));
endmodule

bind hbridge_phase_gen hbridge_phase_gen_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .start(start), .rc(rc),
  .per_q(per_q), .sh_q(sh_q), .off_q(off_q), .leg_a_hi(leg_a_hi),
  .leg_a_lo(leg_a_lo), .leg_b_hi(leg_b_hi), .leg_b_lo(leg_b_lo));

// File: tb/hbridge_phase_gen_tb.sv
`timescale 1ns/1ps
module hbridge_phase_gen_tb_top;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0;
  logic [CNT_W-1:0] period_i = CNT_W'(12);
  logic signed [CNT_W-1:0] shift_i = '0;
  logic signed [CNT_W-1:0] offset_i = '0;
  logic leg_a_hi, leg_a_lo, leg_b_hi, leg_b_lo;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hbridge_phase_gen #(.CNT_W(CNT_W), .DEF_PERIOD(100)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .period_i(period_i),
    .shift_i(shift_i), .offset_i(offset_i), .leg_a_hi(leg_a_hi),
    .leg_a_lo(leg_a_lo), .leg_b_hi(leg_b_hi), .leg_b_lo(leg_b_lo));

  function automatic bit exp_hi(int j, int ph, int p);
    int m;
    m = ((j - ph) % p + p) % p;
    return m < (p / 2);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic set_cmd(int p, int sh, int off);
    period_i = CNT_W'(p);
    shift_i  = CNT_W'(sh);
    offset_i = CNT_W'(off);
  endtask

  task automatic do_sync();
    @(negedge clk) sync_i = 1'b1;
    @(negedge clk) sync_i = 1'b0;
  endtask

  task automatic run_seg(int n, int j0, int p, int off, int sh, string req);
    for (int k = 0; k < n; k++) begin
      bit ea, eb;
      @(negedge clk);
      ea = exp_hi(j0 + k, off, p);
      eb = exp_hi(j0 + k, off + sh, p);
      chk(leg_a_hi == ea && leg_a_lo == !ea, req, "leg A hi/lo", {leg_a_hi, leg_a_lo}, {ea, !ea});
      chk(leg_b_hi == eb && leg_b_lo == !eb, req, "leg B hi/lo", {leg_b_hi, leg_b_lo}, {eb, !eb});
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(!leg_a_hi && !leg_a_lo && !leg_b_hi && !leg_b_lo, "R1", "outputs in reset",
        {leg_a_hi, leg_a_lo, leg_b_hi, leg_b_lo}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    set_cmd(12, 3, 0);
    do_sync();
    run_seg(24, 0, 12, 0, 3, "R3/R6 positive shift");
  endtask

  task automatic t_negative();
    set_cmd(12, -4, 0);
    do_sync();
    run_seg(24, 0, 12, 0, -4, "R6 negative shift");
  endtask

  task automatic t_offsets();
    set_cmd(12, 6, 3);
    do_sync();
    run_seg(24, 0, 12, 3, 6, "R5 offset +90");
    set_cmd(12, 2, -3);
    do_sync();
    run_seg(24, 0, 12, -3, 2, "R5 offset -90");
    set_cmd(12, -6, 4);
    do_sync();
    run_seg(24, 0, 12, 4, -6, "R5 offset 120");
  endtask

  task automatic t_clamp();
    set_cmd(12, 20, 30);
    do_sync();
    run_seg(24, 0, 12, 12, 6, "R7 clamp high");
    set_cmd(12, -20, -40);
    do_sync();
    run_seg(24, 0, 12, -12, -6, "R7 clamp low");
  endtask

  task automatic t_midchange();
    set_cmd(12, 2, 0);
    do_sync();
    run_seg(5, 0, 12, 0, 2, "R8 before change");
    set_cmd(10, 5, 1);
    run_seg(7, 5, 12, 0, 2, "R8 ignored mid-period");
    run_seg(20, 0, 10, 1, 5, "R8 applied at start");
  endtask

  task automatic t_sync_mid();
    set_cmd(12, 3, 0);
    do_sync();
    run_seg(5, 0, 12, 0, 3, "R4 before resync");
    do_sync();
    run_seg(24, 0, 12, 0, 3, "R4 after resync");
  endtask

  task automatic t_min_period();
    set_cmd(1, 0, 0);
    do_sync();
    run_seg(8, 0, 2, 0, 0, "R9 period 1");
    set_cmd(0, 1, 0);
    do_sync();
    run_seg(8, 0, 2, 0, 1, "R9 period 0");
  endtask

  task automatic t_odd();
    set_cmd(9, 4, 2);
    do_sync();
    run_seg(18, 0, 9, 2, 4, "R3 odd period");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_negative();
    t_offsets();
    t_clamp();
    t_midchange();
    t_sync_mid();
    t_min_period();
    t_odd();
    t_reset();
    t_basic();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule